// File: doc/BRIEF.md
# Per-Channel Limit Alert Monitor

This block watches a stream of conversion results from a multi-channel converter. Each result arrives with a channel number. The block compares the result against that channel's programmable upper and lower bounds. A result that crosses a bound latches a status bit for that channel and that direction. The status bit stays set until the result comes back inside the bound by at least the channel's hysteresis margin, or until software clears it. The bits of all channels form one status vector. A single alert output shows whether any bit is set. That output can be enabled or disabled, and its polarity is programmable.

Every accepted result is also repacked into a result word. The top bit of the word is a flag that shows whether any status bit is set once the new result has been taken into account. It is followed by a zero bit, the channel number and the left-aligned data field. A channel whose hysteresis register holds all ones raises no alerts. Instead, its two bound registers become running maximum and minimum capture registers. The register bus decode sits outside this block. This block sees plain write strobes and a registered read port.

Top module: `limit_alert_monitor`

## Requirements
- R1: A result strictly greater than its channel's upper bound sets status bit 2*ch (upper flag); a result equal to the bound does not.
- R2: A result strictly less than its channel's lower bound sets status bit 2*ch+1 (lower flag).
- R3: A set upper flag clears only when a result on that channel is at or below upper bound minus hysteresis, where that difference saturates at zero.
- R4: A set lower flag clears only when a result on that channel is at or above lower bound plus hysteresis, where that sum saturates at full scale (0xFFF).
- R5: After reset every upper bound is 0xFFF, every lower bound is 0, every hysteresis is 8 on the 12-bit field (2 LSB, left-aligned, for 10-bit data), the status vector is 0 and the alert output is high (inactive).
- R6: A set flag of one channel is kept while results arrive on other channels, so flags from several channels accumulate.
- R7: A config write with bits [3:2] = 2'b11 clears the whole status vector, and so does a status write of all ones. A status write of any other value has no effect.
- R8: When a channel's hysteresis is 0xFFF, a result above its upper register replaces that register and a result below its lower register replaces that register. No status bit changes.
- R9: One cycle after res_valid, result_valid_o pulses and result_word_o = {flag, 0, ch[1:0], data[11:0]}. The flag is the OR of the status vector after that result, and 10-bit data is padded with two zero LSBs.
- R10: alert_o = (enable & |status) XOR NOT polarity, where config bit 1 is the enable (reset 1) and bit 0 is the polarity (1 = active high, reset 0). It is registered in the same cycle as the status vector.
- R11: Bound and hysteresis registers are written through lim_we/lim_ch/lim_sel (0 upper, 1 lower, 2 hysteresis, 3 no target). They are read back on rd_data_o one cycle after rd_ch/rd_sel are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | Conversion result strobe |
| res_ch | input | 2 | Channel of the result |
| res_data | input | RES_BITS | Result value |
| lim_we | input | 1 | Bound/hysteresis write strobe |
| lim_ch | input | 2 | Channel written |
| lim_sel | input | 2 | Register written (0 upper, 1 lower, 2 hysteresis) |
| lim_wdata | input | 12 | Write value |
| cfg_we | input | 1 | Config write strobe |
| cfg_wdata | input | 4 | [0] polarity, [1] enable, [3:2] clear when 11 |
| status_we | input | 1 | Status write strobe (all ones clears) |
| status_wdata | input | 8 | Status write value |
| rd_ch | input | 2 | Read-back channel |
| rd_sel | input | 2 | Read-back register select |
| rd_data_o | output | 12 | Registered read-back value |
| status_o | output | 8 | Status vector, two bits per channel |
| alert_o | output | 1 | Alert output, programmable polarity |
| result_valid_o | output | 1 | Result word valid pulse |
| result_word_o | output | 16 | Flag, zero, channel, data |

## Verification
On every cycle, the assertions check four things. A violation sets its flag, a flag survives results on other channels, a channel in capture mode leaves the status vector untouched, and both the alert output and the result flag stay consistent with the status vector. Only the bench scenarios can show the exact release points of the hysteresis band, including the saturated cases at zero and full scale. The same goes for the running maximum and minimum values held in capture mode, and for the packed contents of each result word.

// File: rtl/lam_pkg.sv
package lam_pkg;
  localparam int FIELD_W = 12;
  typedef logic [FIELD_W-1:0] field_t;
  typedef enum logic [1:0] {
    SEL_UPPER = 2'd0,
    SEL_LOWER = 2'd1,
    SEL_HYST  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/lam_chan_regs.sv
module lam_chan_regs
  import lam_pkg::*;
#(
  parameter field_t HYST_RST = field_t'(8)
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   wr_en,
  input  logic [1:0] wr_sel,
  input  field_t wr_data,
  input  logic   cap_upper,
  input  logic   cap_lower,
  input  field_t cap_data,
  output field_t upper_q,
  output field_t lower_q,
  output field_t hyst_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q <= '1;
      lower_q <= '0;
      hyst_q  <= HYST_RST;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_UPPER: upper_q <= wr_data;
        SEL_LOWER: lower_q <= wr_data;
        SEL_HYST:  hyst_q  <= wr_data;
        default: ;
      endcase
    end else begin
      if (cap_upper) upper_q <= cap_data;
      if (cap_lower) lower_q <= cap_data;
    end
  end
endmodule

// File: rtl/lam_chan_eval.sv
module lam_chan_eval
  import lam_pkg::*;
(
  input  field_t data,
  input  field_t upper,
  input  field_t lower,
  input  field_t hyst,
  input  logic   cur_up,
  input  logic   cur_lo,
  output logic   nxt_up,
  output logic   nxt_lo,
  output logic   cap_upper,
  output logic   cap_lower
);
  localparam field_t FULL = '1;
  field_t up_release, lo_release;
  logic   capture_mode;

  always_comb begin
    capture_mode = &hyst;
    up_release   = (upper >= hyst) ? field_t'(upper - hyst) : '0;
    lo_release   = (lower > field_t'(FULL - hyst)) ? FULL : field_t'(lower + hyst);
    if (capture_mode) begin
      nxt_up    = cur_up;
      nxt_lo    = cur_lo;
      cap_upper = data > upper;
      cap_lower = data < lower;
    end else begin
      nxt_up    = cur_up ? (data > up_release) : (data > upper);
      nxt_lo    = cur_lo ? (data < lo_release) : (data < lower);
      cap_upper = 1'b0;
      cap_lower = 1'b0;
    end
  end
endmodule

// File: rtl/limit_alert_monitor.sv
module limit_alert_monitor
  import lam_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int RES_BITS = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        res_valid,
  input  logic [$clog2(NUM_CH)-1:0]   res_ch,
  input  logic [RES_BITS-1:0]         res_data,
  input  logic                        lim_we,
  input  logic [$clog2(NUM_CH)-1:0]   lim_ch,
  input  logic [1:0]                  lim_sel,
  input  logic [FIELD_W-1:0]          lim_wdata,
  input  logic                        cfg_we,
  input  logic [3:0]                  cfg_wdata,
  input  logic                        status_we,
  input  logic [2*NUM_CH-1:0]         status_wdata,
  input  logic [$clog2(NUM_CH)-1:0]   rd_ch,
  input  logic [1:0]                  rd_sel,
  output logic [FIELD_W-1:0]          rd_data_o,
  output logic [2*NUM_CH-1:0]         status_o,
  output logic                        alert_o,
  output logic                        result_valid_o,
  output logic [FIELD_W+1+$clog2(NUM_CH):0] result_word_o
);
  localparam int     CH_W     = $clog2(NUM_CH);
  localparam int     ST_W     = 2 * NUM_CH;
  localparam int     PAD      = FIELD_W - RES_BITS;
  localparam int     WORD_W   = FIELD_W + 2 + CH_W;
  localparam field_t HYST_RST = field_t'((RES_BITS == 12 ? 8 : 2) << PAD);

  field_t          data_f;
  field_t          upper_arr [NUM_CH];
  field_t          lower_arr [NUM_CH];
  field_t          hyst_arr  [NUM_CH];
  logic [ST_W-1:0] upd, status_nxt;
  logic            clr_req, en_q, pol_q, en_nxt, pol_nxt;

  assign data_f = field_t'(res_data) << PAD;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic wr_hit, res_hit, nu, nl, cu, cl;
    assign wr_hit  = lim_we && (lim_ch == CH_W'(g));
    assign res_hit = res_valid && (res_ch == CH_W'(g));

    lam_chan_regs #(.HYST_RST(HYST_RST)) i_regs (
      .clk(clk), .rst(rst), .wr_en(wr_hit), .wr_sel(lim_sel), .wr_data(lim_wdata),
      .cap_upper(res_hit && cu), .cap_lower(res_hit && cl), .cap_data(data_f),
      .upper_q(upper_arr[g]), .lower_q(lower_arr[g]), .hyst_q(hyst_arr[g])
    );

    lam_chan_eval i_eval (
      .data(data_f), .upper(upper_arr[g]), .lower(lower_arr[g]), .hyst(hyst_arr[g]),
      .cur_up(status_o[2*g]), .cur_lo(status_o[2*g+1]),
      .nxt_up(nu), .nxt_lo(nl), .cap_upper(cu), .cap_lower(cl)
    );

    assign upd[2*g]   = res_hit ? nu : status_o[2*g];
    assign upd[2*g+1] = res_hit ? nl : status_o[2*g+1];

    // R1: a result above a non-capture channel's upper bound sets its upper flag
    a_r1_upper_sets: assert property (@(posedge clk) disable iff (rst)
      (res_hit && !clr_req && !(&hyst_arr[g]) && data_f > upper_arr[g]) |=> status_o[2*g]);

    // R2: a result below the lower bound sets the lower flag
    a_r2_lower_sets: assert property (@(posedge clk) disable iff (rst)
      (res_hit && !clr_req && !(&hyst_arr[g]) && data_f < lower_arr[g]) |=> status_o[2*g+1]);

    // R6: flags persist while other channels report
    a_r6_keep_up: assert property (@(posedge clk) disable iff (rst)
      (status_o[2*g] && !res_hit && !clr_req) |=> status_o[2*g]);
    a_r6_keep_lo: assert property (@(posedge clk) disable iff (rst)
      (status_o[2*g+1] && !res_hit && !clr_req) |=> status_o[2*g+1]);

    // R8: capture mode never changes the status vector
    a_r8_capture_quiet: assert property (@(posedge clk) disable iff (rst)
      (res_hit && (&hyst_arr[g]) && !clr_req) |=> $stable(status_o));
  end

  assign clr_req    = (cfg_we && cfg_wdata[3:2] == 2'b11) || (status_we && (&status_wdata));
  assign status_nxt = clr_req ? '0 : upd;
  assign en_nxt     = cfg_we ? cfg_wdata[1] : en_q;
  assign pol_nxt    = cfg_we ? cfg_wdata[0] : pol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o       <= '0;
      en_q           <= 1'b1;
      pol_q          <= 1'b0;
      alert_o        <= 1'b1;
      result_valid_o <= 1'b0;
      result_word_o  <= '0;
    end else begin
      status_o       <= status_nxt;
      en_q           <= en_nxt;
      pol_q          <= pol_nxt;
      alert_o        <= (en_nxt & (|status_nxt)) ^ ~pol_nxt;
      result_valid_o <= res_valid;
      if (res_valid) result_word_o <= {|status_nxt, 1'b0, res_ch, data_f};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else begin
      case (reg_sel_e'(rd_sel))
        SEL_UPPER: rd_data_o <= upper_arr[rd_ch];
        SEL_LOWER: rd_data_o <= lower_arr[rd_ch];
        SEL_HYST:  rd_data_o <= hyst_arr[rd_ch];
        default:   rd_data_o <= '0;
      endcase
    end
  end

  // R9: the word flag mirrors the status vector it was formed with
  a_r9_flag_matches: assert property (@(posedge clk) disable iff (rst)
    result_valid_o |-> (result_word_o[WORD_W-1] == (|status_o)));

  // R10: alert output follows enable, polarity and status
  a_r10_alert_level: assert property (@(posedge clk) disable iff (rst)
    alert_o == ((en_q & (|status_o)) ^ ~pol_q));
endmodule

// File: tb/test_limit_alert_monitor.sv
module test_limit_alert_monitor;
  localparam int PERIOD = 10;

  logic clk = 0, rst = 1;
  logic res_valid = 0; logic [1:0] res_ch = 0; logic [11:0] res_data = 0;
  logic lim_we = 0; logic [1:0] lim_ch = 0, lim_sel = 0; logic [11:0] lim_wdata = 0;
  logic cfg_we = 0; logic [3:0] cfg_wdata = 0;
  logic status_we = 0; logic [7:0] status_wdata = 0;
  logic [1:0] rd_ch = 0, rd_sel = 0;
  logic [11:0] rd_data_o; logic [7:0] status_o; logic alert_o, result_valid_o;
  logic [15:0] result_word_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  limit_alert_monitor i_limit_alert_monitor (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_ch(res_ch), .res_data(res_data),
    .lim_we(lim_we), .lim_ch(lim_ch), .lim_sel(lim_sel), .lim_wdata(lim_wdata),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .status_we(status_we), .status_wdata(status_wdata),
    .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_data_o(rd_data_o), .status_o(status_o),
    .alert_o(alert_o), .result_valid_o(result_valid_o), .result_word_o(result_word_o));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(logic [1:0] ch, logic [11:0] d);
    @(negedge clk); res_valid = 1; res_ch = ch; res_data = d;
    @(negedge clk); res_valid = 0;
  endtask

  task automatic wr_lim(logic [1:0] ch, logic [1:0] sel, logic [11:0] d);
    @(negedge clk); lim_we = 1; lim_ch = ch; lim_sel = sel; lim_wdata = d;
    @(negedge clk); lim_we = 0;
  endtask

  task automatic wr_cfg(logic [3:0] d);
    @(negedge clk); cfg_we = 1; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic wr_status(logic [7:0] d);
    @(negedge clk); status_we = 1; status_wdata = d;
    @(negedge clk); status_we = 0;
  endtask

  task automatic rd(logic [1:0] ch, logic [1:0] sel, output logic [11:0] v);
    @(negedge clk); rd_ch = ch; rd_sel = sel;
    @(negedge clk); v = rd_data_o;
  endtask

  task automatic t_reset();
    logic [11:0] v;
    chk("R5 status", status_o, 8'h00);
    chk("R5 alert", alert_o, 1);
    rd(2'd0, 2'd0, v); chk("R5 upper", v, 12'hFFF);
    rd(2'd2, 2'd1, v); chk("R5 lower", v, 12'h000);
    rd(2'd3, 2'd2, v); chk("R5 hyst", v, 12'h008);
  endtask

  task automatic t_upper();
    logic [11:0] v;
    wr_lim(2'd0, 2'd0, 12'h800);
    rd(2'd0, 2'd0, v); chk("R11 readback", v, 12'h800);
    send(2'd0, 12'h800); chk("R1 equal no set", status_o, 8'h00);
    send(2'd0, 12'h801);
    chk("R1 set", status_o, 8'h01);
    chk("R9 word", result_word_o, 16'h8801);
    chk("R9 valid", result_valid_o, 1);
    chk("R10 alert low", alert_o, 0);
    send(2'd0, 12'h7F9); chk("R3 inside band holds", status_o, 8'h01);
    send(2'd0, 12'h7F8);
    chk("R3 release", status_o, 8'h00);
    chk("R9 word clear", result_word_o, 16'h07F8);
    chk("R10 alert idle", alert_o, 1);
  endtask

  task automatic t_lower();
    wr_lim(2'd1, 2'd1, 12'h100);
    wr_lim(2'd1, 2'd2, 12'h010);
    send(2'd1, 12'h0FF);
    chk("R2 set", status_o, 8'h08);
    chk("R9 word ch1", result_word_o, 16'h90FF);
    send(2'd1, 12'h10F); chk("R4 holds", status_o, 8'h08);
    send(2'd1, 12'h110); chk("R4 release", status_o, 8'h00);
  endtask

  task automatic t_accum();
    wr_lim(2'd2, 2'd0, 12'h400);
    wr_lim(2'd3, 2'd1, 12'h200);
    send(2'd2, 12'h500); chk("R6 first", status_o, 8'h10);
    send(2'd3, 12'h100); chk("R6 accumulate", status_o, 8'h90);
    send(2'd0, 12'h100);
    chk("R6 other channel keeps", status_o, 8'h90);
    chk("R9 flag from others", result_word_o, 16'h8100);
  endtask

  task automatic t_clear();
    wr_status(8'h0F); chk("R7 non-ones ignored", status_o, 8'h90);
    wr_status(8'hFF); chk("R7 status clear", status_o, 8'h00);
    chk("R7 alert idle", alert_o, 1);
    send(2'd2, 12'h500); chk("R7 re-set", status_o, 8'h10);
    wr_cfg(4'hE);
    chk("R7 cfg clear", status_o, 8'h00);
    chk("R7 cfg clear alert", alert_o, 1);
  endtask

  task automatic t_polarity();
    send(2'd2, 12'h500); chk("R10 active low", alert_o, 0);
    wr_cfg(4'h3); chk("R10 active high", alert_o, 1);
    wr_cfg(4'h1); chk("R10 disabled high pol", alert_o, 0);
    wr_cfg(4'h0); chk("R10 disabled low pol", alert_o, 1);
    wr_cfg(4'h2); chk("R10 re-enabled", alert_o, 0);
    wr_status(8'hFF); chk("R10 cleared", alert_o, 1);
  endtask

  task automatic t_saturate();
    wr_lim(2'd3, 2'd1, 12'h000);
    wr_lim(2'd3, 2'd0, 12'h005);
    wr_lim(2'd3, 2'd2, 12'h010);
    send(2'd3, 12'h006); chk("R3 sat set", status_o, 8'h40);
    send(2'd3, 12'h001); chk("R3 sat holds", status_o, 8'h40);
    send(2'd3, 12'h000); chk("R3 sat release", status_o, 8'h00);
    wr_lim(2'd3, 2'd0, 12'hFFF);
    wr_lim(2'd3, 2'd1, 12'hFFA);
    send(2'd3, 12'hFF0); chk("R4 sat set", status_o, 8'h80);
    send(2'd3, 12'hFFE); chk("R4 sat holds", status_o, 8'h80);
    send(2'd3, 12'hFFF); chk("R4 sat release", status_o, 8'h00);
  endtask

  task automatic t_capture();
    logic [11:0] v;
    wr_lim(2'd1, 2'd2, 12'hFFF);
    wr_lim(2'd1, 2'd0, 12'h000);
    wr_lim(2'd1, 2'd1, 12'hFFF);
    send(2'd1, 12'h300);
    chk("R8 no alert", status_o, 8'h00);
    chk("R8 word flag", result_word_o, 16'h1300);
    send(2'd1, 12'h100);
    send(2'd1, 12'h500);
    send(2'd1, 12'h200);
    chk("R8 still quiet", status_o, 8'h00);
    rd(2'd1, 2'd0, v); chk("R8 max", v, 12'h500);
    rd(2'd1, 2'd1, v); chk("R8 min", v, 12'h100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_upper();
    t_lower();
    t_accum();
    t_clear();
    t_polarity();
    t_saturate();
    t_capture();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule